// File: doc/BRIEF.md
# UART Auto-Baud Rate Detector

This block sits in front of a UART receiver that runs without a precision oscillator. The block learns the line rate from the synchronization byte that opens every frame. The transmitter sends 0x55. With its start bit, that byte puts a train of single-bit-wide low pulses on the line. The block syncs the receive line into its clock domain and times each low pulse in cycles of its own clock, which is also the count clock. It then averages four such widths into one bit-period estimate.

The estimate must land inside a ±5% window around one of two nominal bit-period counts. The slow rate sits at 104 counts and the fast rate at 52, so the two rates differ by a factor of two. If the estimate lands in a window, the block locks and presents the matching clock divisor to the downstream receiver. If it lands in neither window, the block flags an error and waits for a fresh synchronization byte.

The receive line is steered in two phases. While the block measures, the UART side sees an idle-high line. Once the block locks, the raw line passes straight through to the receiver.

Top module: `autobaud_detect`

## Requirements
- R1: After reset, locked_o, err_o and rate_fast_o are 0, div_o is 0 and uart_rx_o is 1.
- R2: While waiting, the first falling edge of the synchronized line starts a measurement. Each low pulse is measured as the number of clock cycles from its falling edge to the next rising edge.
- R3: The first four low-pulse widths after the start are summed. The estimate is that sum shifted right by 2 (floor). Low pulses after the fourth do not take part.
- R4: An estimate from 99 to 109 inclusive makes the block lock: locked_o=1, rate_fast_o=0, div_o=104, err_o=0.
- R5: An estimate from 50 to 54 inclusive makes the block lock: locked_o=1, rate_fast_o=1, div_o=52, err_o=0.
- R6: Any other estimate sets err_o=1, locked_o=0 and div_o=0, and the block goes back to waiting. A later synchronization byte that locks clears err_o.
- R7: The pulse counter saturates at 255 instead of wrapping. A low pulse longer than 255 cycles counts as 255.
- R8: While not locked, uart_rx_o is 1 whatever rx_i does. While locked, uart_rx_o equals rx_i combinationally.
- R9: While locked, further activity on rx_i leaves locked_o, rate_fast_o and div_o unchanged.
- R10: The synchronous restart_i returns the block to waiting at the next clock edge and clears locked_o, err_o, rate_fast_o and div_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock; one count per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Synchronous return to waiting |
| rx_i | input | 1 | Raw receive line |
| uart_rx_o | output | 1 | Receive line steered to the UART |
| locked_o | output | 1 | Rate detected, divisor valid |
| rate_fast_o | output | 1 | 1 = fast rate, 0 = slow rate |
| div_o | output | 8 | Divisor for the UART clock |
| err_o | output | 1 | Last measurement fell outside both windows |

## Verification
The bench drives low pulses at the exact window edges (49/50, 54/55, 98/99, 109/110). A design with an off-by-one bound locks where it should flag, or flags where it should lock.

Mixed-width sets check that the average is taken over four pulses and floored. These sets have single pulses out of window but an in-window average, and sums that floor across a bound. A fifth long pulse is sent to show that it is ignored.

One over-long pulse is chosen so that a wrapping counter would classify it as the fast rate, where saturation gives the slow rate. Random rounds put widths near each nominal count and between them. Those rounds also check the steering of the line, that a new byte cannot disturb an existing lock, and recovery from an error without a restart.

// File: rtl/abd_pkg.sv
package abd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_MEASURE = 2'd1,
    ST_DONE    = 2'd2,
    ST_ERROR   = 2'd3
  } abd_state_e;
endpackage

// File: rtl/abd_sync_edge.sv
module abd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic line_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sr_q[STAGES-1];

  assign line_o = sr_q[STAGES-1];
  assign fall_o = prev_q & ~line_o;
  assign rise_o = ~prev_q & line_o;
endmodule

// File: rtl/abd_pulse_timer.sv
module abd_pulse_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             line_i,
  input  logic             fall_i,
  input  logic             rise_i,
  output logic             cap_valid_o,
  output logic [CNT_W-1:0] cap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  // reload on fall, count low cycles, hold at max
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                             cnt_q <= '0;
    else if (en_i && fall_i)                 cnt_q <= CNT_W'(1);
    else if (en_i && !line_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;

  assign cap_valid_o = en_i & rise_i;
  assign cap_o       = cnt_q;
endmodule

// File: rtl/abd_accum.sv
module abd_accum #(
  parameter int CNT_W   = 8,
  parameter int NUM_CAP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             cap_valid_i,
  input  logic [CNT_W-1:0] cap_i,
  output logic             last_o,
  output logic [CNT_W-1:0] avg_o
);
  localparam int SH    = $clog2(NUM_CAP);
  localparam int SUM_W = CNT_W + SH;
  localparam int IDX_W = (SH > 0) ? SH : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_CAP - 1);

  logic [SUM_W-1:0] sum_q, sum_nxt;
  logic [IDX_W-1:0] idx_q;

  assign sum_nxt = sum_q + SUM_W'(cap_i);
  assign avg_o   = sum_nxt[SUM_W-1:SH];
  assign last_o  = cap_valid_i && (idx_q == IDX_LAST);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sum_q <= '0;
      idx_q <= '0;
    end else if (clear_i || last_o) begin
      sum_q <= '0;
      idx_q <= '0;
    end else if (cap_valid_i) begin
      sum_q <= sum_nxt;
      idx_q <= idx_q + 1'b1;
    end
endmodule

// File: rtl/abd_classify.sv
module abd_classify #(
  parameter int CNT_W    = 8,
  parameter int NOM_SLOW = 104,
  parameter int NOM_FAST = 52,
  parameter int TOL_PCT  = 5
) (
  input  logic [CNT_W-1:0] avg_i,
  output logic             hit_slow_o,
  output logic             hit_fast_o
);
  localparam int SLOW_TOL = NOM_SLOW * TOL_PCT / 100;
  localparam int FAST_TOL = NOM_FAST * TOL_PCT / 100;
  localparam int SLOW_LO  = NOM_SLOW - SLOW_TOL;
  localparam int SLOW_HI  = NOM_SLOW + SLOW_TOL;
  localparam int FAST_LO  = NOM_FAST - FAST_TOL;
  localparam int FAST_HI  = NOM_FAST + FAST_TOL;

  int avg_int;
  assign avg_int    = int'(avg_i);
  assign hit_slow_o = (avg_int >= SLOW_LO) && (avg_int <= SLOW_HI);
  assign hit_fast_o = (avg_int >= FAST_LO) && (avg_int <= FAST_HI);
endmodule

// File: rtl/autobaud_detect.sv
module autobaud_detect #(
  parameter int CNT_W    = 8,
  parameter int NUM_CAP  = 4,
  parameter int SYNC_STG = 2,
  parameter int NOM_SLOW = 104,
  parameter int NOM_FAST = 52,
  parameter int TOL_PCT  = 5,
  parameter int DIV_W    = 8,
  parameter int DIV_SLOW = 104,
  parameter int DIV_FAST = 52
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             rx_i,
  output logic             uart_rx_o,
  output logic             locked_o,
  output logic             rate_fast_o,
  output logic [DIV_W-1:0] div_o,
  output logic             err_o
);
  import abd_pkg::*;

  abd_state_e       state_q, state_d;
  logic             line, fall, rise;
  logic             meas_en, cap_valid, acc_clear, acc_last;
  logic [CNT_W-1:0] cap, avg;
  logic             hit_slow, hit_fast;
  logic [DIV_W-1:0] div_q;
  logic             fast_q, err_q;

  abd_sync_edge #(.STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i),
    .line_o(line), .fall_o(fall), .rise_o(rise)
  );

  assign meas_en = (state_q == ST_IDLE) || (state_q == ST_MEASURE);

  abd_pulse_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(meas_en), .line_i(line),
    .fall_i(fall), .rise_i(rise), .cap_valid_o(cap_valid), .cap_o(cap)
  );

  assign acc_clear = restart_i || (state_q != ST_MEASURE);

  abd_accum #(.CNT_W(CNT_W), .NUM_CAP(NUM_CAP)) u_accum (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(acc_clear),
    .cap_valid_i(cap_valid), .cap_i(cap), .last_o(acc_last), .avg_o(avg)
  );

  abd_classify #(
    .CNT_W(CNT_W), .NOM_SLOW(NOM_SLOW), .NOM_FAST(NOM_FAST), .TOL_PCT(TOL_PCT)
  ) u_class (
    .avg_i(avg), .hit_slow_o(hit_slow), .hit_fast_o(hit_fast)
  );

  logic decide;
  assign decide = (state_q == ST_MEASURE) && acc_last && !restart_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (fall) state_d = ST_MEASURE;
      ST_MEASURE: if (acc_last) state_d = (hit_slow || hit_fast) ? ST_DONE : ST_ERROR;
      ST_DONE:    state_d = ST_DONE;
      ST_ERROR:   state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
    if (restart_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      div_q  <= '0;
      fast_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (restart_i) begin
      div_q  <= '0;
      fast_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (decide) begin
      if (hit_slow) begin
        div_q  <= DIV_W'(DIV_SLOW);
        fast_q <= 1'b0;
        err_q  <= 1'b0;
      end else if (hit_fast) begin
        div_q  <= DIV_W'(DIV_FAST);
        fast_q <= 1'b1;
        err_q  <= 1'b0;
      end else begin
        div_q  <= '0;
        fast_q <= 1'b0;
        err_q  <= 1'b1;
      end
    end

  assign locked_o    = (state_q == ST_DONE);
  assign uart_rx_o   = locked_o ? rx_i : 1'b1;
  assign div_o       = div_q;
  assign rate_fast_o = fast_q;
  assign err_o       = err_q;
endmodule

// File: rtl/autobaud_detect_chk.sv
module autobaud_detect_chk #(
  parameter int DIV_W    = 8,
  parameter int DIV_SLOW = 104,
  parameter int DIV_FAST = 52
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             restart_i,
  input logic             rx_i,
  input logic             uart_rx_o,
  input logic             locked_o,
  input logic             rate_fast_o,
  input logic [DIV_W-1:0] div_o,
  input logic             err_o
);
  // R8
  steer_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> uart_rx_o);

  // R8
  steer_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> (uart_rx_o == rx_i));

  // R4
  div_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> ((div_o == DIV_W'(DIV_SLOW) && !rate_fast_o) ||
                  (div_o == DIV_W'(DIV_FAST) && rate_fast_o)));

  // R9
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !restart_i) |=> (locked_o && $stable(div_o) && $stable(rate_fast_o)));

  // R10
  restart_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!locked_o && !err_o && div_o == '0));

  // R6
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && locked_o));

  // R6
  err_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (div_o == '0));
endmodule

bind autobaud_detect autobaud_detect_chk #(
  .DIV_W(DIV_W), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart_i), .rx_i(rx_i),
  .uart_rx_o(uart_rx_o), .locked_o(locked_o), .rate_fast_o(rate_fast_o),
  .div_o(div_o), .err_o(err_o)
);

// File: tb/autobaud_detect_bench.sv
module autobaud_detect_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       restart_i = 1'b0;
  logic       rx_i = 1'b1;
  logic       uart_rx_o, locked_o, rate_fast_o, err_o;
  logic [7:0] div_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  autobaud_detect u_autobaud_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart_i), .rx_i(rx_i),
    .uart_rx_o(uart_rx_o), .locked_o(locked_o), .rate_fast_o(rate_fast_o),
    .div_o(div_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // 0 = error, 1 = slow, 2 = fast
  function automatic int classify(input int w0, input int w1, input int w2, input int w3);
    int a;
    a = (sat(w0) + sat(w1) + sat(w2) + sat(w3)) / 4;
    if (a >= 99 && a <= 109) return 1;
    if (a >= 50 && a <= 54)  return 2;
    return 0;
  endfunction

  function automatic int sat(input int w);
    return (w > 255) ? 255 : w;
  endfunction

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic send(input int w0, input int w1, input int w2, input int w3,
                      input int w4, input int nlow, input int hi);
    int w[5];
    w = '{w0, w1, w2, w3, w4};
    for (int k = 0; k < nlow; k++) begin
      @(negedge clk_i); rx_i = 1'b0;
      wait_cyc(w[k]);
      rx_i = 1'b1;
      wait_cyc(hi);
    end
    wait_cyc(200);
  endtask

  task automatic do_restart();
    @(negedge clk_i); restart_i = 1'b1;
    @(negedge clk_i); restart_i = 1'b0;
  endtask

  task automatic check_result(input int cls, input string tag);
    if (cls == 1) begin
      chk(locked_o === 1'b1 && rate_fast_o === 1'b0, {tag, " lock slow"}, int'(locked_o), 1);
      chk(div_o === 8'd104, {tag, " div slow"}, int'(div_o), 104);
    end else if (cls == 2) begin
      chk(locked_o === 1'b1 && rate_fast_o === 1'b1, {tag, " lock fast"}, int'(locked_o), 1);
      chk(div_o === 8'd52, {tag, " div fast"}, int'(div_o), 52);
    end else begin
      chk(err_o === 1'b1 && locked_o === 1'b0, {tag, " error"}, int'(err_o), 1);
      chk(div_o === 8'd0, {tag, " div zero"}, int'(div_o), 0);
    end
  endtask

  initial begin
    wait_cyc(200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed, b, w[4], cls;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    wait_cyc(3);
    // R1
    chk(locked_o === 0 && err_o === 0 && rate_fast_o === 0, "R1 flags", int'(locked_o), 0);
    chk(div_o === 0 && uart_rx_o === 1, "R1 outputs", int'(div_o), 0);
    rst_ni = 1'b1;
    wait_cyc(3);

    // R8 idle steering while not locked
    rx_i = 1'b0; #1;
    chk(uart_rx_o === 1'b1, "R8 held high", int'(uart_rx_o), 1);
    rx_i = 1'b1;
    wait_cyc(300);
    do_restart();

    // R2 R4 nominal slow
    send(104, 104, 104, 104, 104, 5, 104);
    check_result(1, "R2 R4 nominal");
    // R8 pass-through
    @(negedge clk_i); rx_i = 1'b0; #1;
    chk(uart_rx_o === 1'b0, "R8 pass low", int'(uart_rx_o), 0);
    rx_i = 1'b1; #1;
    chk(uart_rx_o === 1'b1, "R8 pass high", int'(uart_rx_o), 1);
    // R9 fast byte while locked
    send(52, 52, 52, 52, 52, 5, 52);
    chk(locked_o === 1 && div_o === 8'd104 && rate_fast_o === 0, "R9 lock held", int'(div_o), 104);

    // R10 restart
    do_restart();
    chk(locked_o === 0 && div_o === 0 && err_o === 0, "R10 cleared", int'(div_o), 0);

    // R5 window edges fast
    send(50, 50, 50, 50, 50, 5, 50);  check_result(2, "R5 low edge");  do_restart();
    send(54, 54, 54, 54, 54, 5, 54);  check_result(2, "R5 high edge"); do_restart();
    send(49, 49, 49, 49, 49, 5, 49);  check_result(0, "R6 below fast"); do_restart();
    send(55, 55, 55, 55, 55, 5, 55);  check_result(0, "R6 above fast"); do_restart();
    // R4 window edges slow
    send(99, 99, 99, 99, 99, 5, 99);      check_result(1, "R4 low edge");  do_restart();
    send(109, 109, 109, 109, 109, 5, 109); check_result(1, "R4 high edge"); do_restart();
    send(98, 98, 98, 98, 98, 5, 98);      check_result(0, "R6 below slow"); do_restart();
    send(110, 110, 110, 110, 110, 5, 110); check_result(0, "R6 above slow"); do_restart();

    // R3 average over mixed widths, floor, fifth ignored
    send(90, 110, 110, 106, 104, 5, 100);  check_result(1, "R3 mixed avg"); do_restart();
    send(110, 110, 110, 109, 104, 5, 100); check_result(1, "R3 floor 439"); do_restart();
    send(104, 104, 104, 104, 240, 5, 100); check_result(1, "R3 fifth ignored"); do_restart();

    // R7 saturation: wrap would give fast
    send(300, 60, 60, 40, 60, 5, 100);     check_result(1, "R7 saturate"); do_restart();

    // R6 recovery without restart
    send(80, 80, 80, 80, 0, 4, 80);
    check_result(0, "R6 error");
    send(52, 52, 52, 52, 52, 5, 52);
    check_result(2, "R6 recovery");
    chk(err_o === 1'b0, "R6 err cleared", int'(err_o), 0);
    do_restart();

    // random rounds
    for (int it = 0; it < 24; it++) begin
      case ($urandom % 4)
        0: b = 104;
        1: b = 52;
        2: b = 78;
        default: b = 130;
      endcase
      for (int k = 0; k < 4; k++) w[k] = b + int'($urandom % 15) - 7;
      cls = classify(w[0], w[1], w[2], w[3]);
      send(w[0], w[1], w[2], w[3], b, 5, b);
      check_result(cls, "R3 random");
      do_restart();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule